// File: doc/BRIEF.md
# Recurrent Omega-Flip Permutation Engine

This block permutes the bits of a word by running one shared stage network again and again, one pass per clock, rather than laying down a separate network for every stage. All stages of the network are wired alike, so one exchange-plus-shuffle path and one unshuffle-plus-exchange path are enough. A pulse on `start` captures the data word and a bank of steering masks. The engine then makes log2(WIDTH) forward (omega) passes and the same number of backward (flip) passes. Together these two phases can produce any permutation of the word's bits.

The steering masks are computed outside the block. Each pass takes WIDTH/2 steering bits. Bit j of a mask swaps the data bits j and j+WIDTH/2. When the last pass ends, `done` pulses for one cycle. The result stays on `dataOut` until the next accepted start.

Top module: `omf_engine`

## Requirements
- R1: During and right after reset, `busy` and `done` are 0 and `dataOut` is all zeros.
- R2: A `start` sampled while the engine is not running (idle, or in its done cycle) loads `dataIn` and `maskIn`, and `busy` is 1 from the next cycle.
- R3: `busy` stays high for exactly 2*log2(WIDTH) cycles (6 at WIDTH=8). `done` rises in the first cycle after `busy` falls, which is 6 clock edges after the edge that took the start.
- R4: `done` is high for one cycle only.
- R5: An omega pass with mask m first swaps bits j and j+WIDTH/2 for each set bit m[j]. It then shuffles the word: the bit at index i moves to index rotate-left-by-1(i), so dcbaDCBA becomes dDcCbBaA.
- R6: A flip pass with mask m first unshuffles the word: the bit at index i moves to index rotate-right-by-1(i). It then applies the same conditional swaps as R5.
- R7: `maskIn` is read as 2*log2(WIDTH) fields of WIDTH/2 bits each, with field s at bits [s*WIDTH/2 +: WIDTH/2]. Fields 0..2 steer omega passes 0..2 in that order, and fields 3..5 steer flip passes 0..2 in that order.
- R8: If the flip fields hold the omega fields in reverse order, the result equals the loaded word.
- R9: If every mask is zero, the result equals the loaded word.
- R10: A `start` that arrives while `busy` is 1 is ignored. It does not change the running computation or its result.
- R11: While idle, `dataOut` holds the last result until a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to load and run |
| dataIn | input | WIDTH | Word to permute |
| maskIn | input | 2*log2(WIDTH)*WIDTH/2 | Steering mask bank, layout per R7 |
| busy | output | 1 | Passes in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| dataOut | output | WIDTH | Current word and final result |

## Verification
Two cases are hard to reach from the ports. The first is a start pulse that lands in the middle of a run. The second is a start that arrives in the very cycle `done` is high, which must be accepted at once. The stimulus aims at both: it raises `start` with a different word partway through a run, and it launches a new operation exactly in the done cycle. A behavioural model follows every pass of every run, so a wrong mask field or a wrong shuffle direction shows up at the pass where it happens. Round trips with random masks, checked against the original word, catch any mismatch between the omega path and the flip path.

// File: rtl/omf_pkg.sv
package omf_pkg;
  // Width of the step index carried in the strobe bundle (up to 16 steps per phase).
  localparam int OMF_IDX_W = 4;

  typedef struct packed {
    logic                 load;
    logic                 doOmega;
    logic                 doFlip;
    logic [OMF_IDX_W-1:0] stepIdx;
  } omf_strobe_t;
endpackage

// File: rtl/omf_stage_net.sv
module omf_stage_net #(
  parameter int WIDTH = 8,
  parameter int LOG2W = 3
) (
  input  logic [WIDTH-1:0]   x,
  input  logic [WIDTH/2-1:0] steer,
  output logic [WIDTH-1:0]   omegaY,
  output logic [WIDTH-1:0]   flipY
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] exchIn;   // exchange applied to the input (omega path)
  logic [WIDTH-1:0] unshuf;   // unshuffled input (flip path)

  // Top-stage exchange: pair j with j+HALF.
  for (genvar j = 0; j < HALF; j++) begin : g_exch
    assign exchIn[j]        = steer[j] ? x[j+HALF] : x[j];
    assign exchIn[j+HALF]   = steer[j] ? x[j]      : x[j+HALF];
    assign flipY[j]         = steer[j] ? unshuf[j+HALF] : unshuf[j];
    assign flipY[j+HALF]    = steer[j] ? unshuf[j]      : unshuf[j+HALF];
  end

  // Index rotations: shuffle = rotate left by one, unshuffle = rotate right by one.
  for (genvar i = 0; i < WIDTH; i++) begin : g_perm
    localparam int ROTL = ((i << 1) | (i >> (LOG2W - 1))) & (WIDTH - 1);
    localparam int ROTR = ((i >> 1) | ((i & 1) << (LOG2W - 1))) & (WIDTH - 1);
    assign omegaY[ROTL] = exchIn[i];
    assign unshuf[ROTR] = x[i];
  end
endmodule

// File: rtl/omf_ctrl.sv
module omf_ctrl
  import omf_pkg::*;
#(
  parameter int STEPS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output omf_strobe_t strobes,
  output logic        busy,
  output logic        done
);
  typedef enum logic [1:0] {S_IDLE, S_OMEGA, S_FLIP, S_DONE} omf_state_e;

  localparam logic [OMF_IDX_W-1:0] LAST_STEP = OMF_IDX_W'(STEPS - 1);

  omf_state_e           state, stateNext;
  logic [OMF_IDX_W-1:0] stepCnt, stepCntNext;

  always_comb begin
    stateNext   = state;
    stepCntNext = stepCnt;
    strobes     = '0;
    case (state)
      S_IDLE, S_DONE: begin
        if (start) begin
          strobes.load = 1'b1;
          stateNext    = S_OMEGA;
          stepCntNext  = '0;
        end else begin
          stateNext = S_IDLE;
        end
      end
      S_OMEGA: begin
        strobes.doOmega = 1'b1;
        strobes.stepIdx = stepCnt;
        if (stepCnt == LAST_STEP) begin
          stateNext   = S_FLIP;
          stepCntNext = '0;
        end else begin
          stepCntNext = stepCnt + 1'b1;
        end
      end
      S_FLIP: begin
        strobes.doFlip  = 1'b1;
        strobes.stepIdx = stepCnt;
        if (stepCnt == LAST_STEP) begin
          stateNext   = S_DONE;
          stepCntNext = '0;
        end else begin
          stepCntNext = stepCnt + 1'b1;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
    end else begin
      state   <= stateNext;
      stepCnt <= stepCntNext;
    end
  end

  assign busy = (state == S_OMEGA) || (state == S_FLIP);
  assign done = (state == S_DONE);

  // R2: an accepted start makes the engine busy on the next cycle.
  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  // R3: the run always ends in the done cycle.
  p_end_in_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R4: done lasts a single cycle.
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: no load strobe while running.
  p_no_load_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobes.load);

  p_strobe_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.doOmega, strobes.doFlip}));
endmodule

// File: rtl/omf_datapath.sv
module omf_datapath
  import omf_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int LOG2W = 3,
  parameter int STEPS = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  omf_strobe_t                   strobes,
  input  logic [WIDTH-1:0]              dataIn,
  input  logic [2*STEPS*(WIDTH/2)-1:0]  maskIn,
  output logic [WIDTH-1:0]              dataOut
);
  localparam int HALF   = WIDTH / 2;
  localparam int MASK_W = 2 * STEPS * HALF;

  logic [WIDTH-1:0]  dataReg;
  logic [MASK_W-1:0] maskBank;
  logic [HALF-1:0]   curSteer;
  logic [WIDTH-1:0]  omegaY, flipY;
  int                slot;

  // Omega pass s uses field s, flip pass s uses field STEPS+s.
  always_comb begin
    slot     = int'(strobes.stepIdx) + (strobes.doFlip ? STEPS : 0);
    curSteer = maskBank[slot*HALF +: HALF];
  end

  omf_stage_net #(.WIDTH(WIDTH), .LOG2W(LOG2W)) net_i (
    .x      (dataReg),
    .steer  (curSteer),
    .omegaY (omegaY),
    .flipY  (flipY)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      maskBank <= '0;
    end else if (strobes.load) begin
      dataReg  <= dataIn;
      maskBank <= maskIn;
    end else if (strobes.doOmega) begin
      dataReg  <= omegaY;
    end else if (strobes.doFlip) begin
      dataReg  <= flipY;
    end
  end

  assign dataOut = dataReg;

  // R11: with no strobe the word is held.
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.load || strobes.doOmega || strobes.doFlip) |=> $stable(dataReg));

  // R10: the mask bank cannot change during a run.
  p_bank_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doOmega || strobes.doFlip) |=> $stable(maskBank));

  // R7: step index stays within one phase.
  p_idx_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doOmega || strobes.doFlip) |-> (int'(strobes.stepIdx) < STEPS));
endmodule

// File: rtl/omf_engine.sv
module omf_engine
  import omf_pkg::*;
#(
  parameter  int WIDTH  = 8,
  localparam int LOG2W  = $clog2(WIDTH),
  localparam int MASK_W = 2 * LOG2W * (WIDTH / 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WIDTH-1:0]  dataIn,
  input  logic [MASK_W-1:0] maskIn,
  output logic              busy,
  output logic              done,
  output logic [WIDTH-1:0]  dataOut
);
  omf_strobe_t strobes;

  omf_ctrl #(.STEPS(LOG2W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  omf_datapath #(.WIDTH(WIDTH), .LOG2W(LOG2W), .STEPS(LOG2W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .dataIn  (dataIn),
    .maskIn  (maskIn),
    .dataOut (dataOut)
  );
endmodule

// File: tb/omf_engine_tb.sv
module omf_engine_tb_top;
  localparam int W  = 8;
  localparam int MW = 24;

  logic          clk = 1'b0;
  logic          rstN;
  logic          start;
  logic [W-1:0]  dataIn;
  logic [MW-1:0] maskIn;
  logic          busy, done;
  logic [W-1:0]  dataOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // Behavioural model state.
  int            mPhase = 0;     // 0 idle, 1..6 running, 7 done
  logic [W-1:0]  mData  = '0;
  logic [MW-1:0] mMasks = '0;

  always #4 clk = ~clk;   // 125 MHz

  omf_engine #(.WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .dataIn(dataIn),
    .maskIn(maskIn), .busy(busy), .done(done), .dataOut(dataOut)
  );

  function automatic logic [W-1:0] exch(logic [W-1:0] x, logic [3:0] m);
    logic [W-1:0] t = x;
    for (int j = 0; j < 4; j++)
      if (m[j]) begin t[j] = x[j+4]; t[j+4] = x[j]; end
    return t;
  endfunction

  function automatic logic [W-1:0] omegaRef(logic [W-1:0] x, logic [3:0] m);
    logic [W-1:0] t = exch(x, m);
    logic [W-1:0] y;
    for (int i = 0; i < W; i++) y[((i << 1) | (i >> 2)) & 7] = t[i];
    return y;
  endfunction

  function automatic logic [W-1:0] flipRef(logic [W-1:0] x, logic [3:0] m);
    logic [W-1:0] u;
    for (int i = 0; i < W; i++) u[((i >> 1) | ((i & 1) << 2)) & 7] = x[i];
    return exch(u, m);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: model follows the edge, outputs compared 2 ns later.
  task automatic tick();
    @(posedge clk);
    if (!rstN) begin
      mPhase = 0; mData = '0; mMasks = '0;
    end else if (mPhase == 0 || mPhase == 7) begin
      if (start) begin mData = dataIn; mMasks = maskIn; mPhase = 1; end
      else mPhase = 0;
    end else begin
      if (mPhase <= 3) mData = omegaRef(mData, mMasks[(mPhase-1)*4 +: 4]);
      else             mData = flipRef(mData, mMasks[(mPhase-1)*4 +: 4]);
      mPhase++;
    end
    #2;
    check("R3 busy", 32'(busy), 32'(mPhase >= 1 && mPhase <= 6));
    check("R4 done", 32'(done), 32'(mPhase == 7));
    check("R5 R6 R11 dataOut", 32'(dataOut), 32'(mData));
  endtask

  task automatic launch(logic [W-1:0] d, logic [MW-1:0] m);
    start = 1'b1; dataIn = d; maskIn = m;
    tick();
    start = 1'b0;
  endtask

  task automatic runOp(logic [W-1:0] d, logic [MW-1:0] m, output logic [W-1:0] res);
    launch(d, m);
    repeat (5) tick();
    check("R3 still busy before last pass", 32'(busy), 32'd1);
    tick();
    check("R3 done after six edges", 32'(done), 32'd1);
    res = dataOut;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] res;
    logic [3:0]   om [3];
    rstN = 1'b0; start = 1'b0; dataIn = '0; maskIn = '0;
    repeat (3) tick();
    check("R1 reset busy", 32'(busy), 32'd0);
    check("R1 reset done", 32'(done), 32'd0);
    check("R1 reset dataOut", 32'(dataOut), 32'd0);
    #1 rstN = 1'b1;
    tick();

    // R9: zero masks give identity.
    runOp(8'hA7, '0, res);
    check("R9 identity", 32'(res), 32'hA7);
    tick();
    check("R4 done single cycle", 32'(done), 32'd0);

    // R5, R7: omega field 0 bit0 only.
    runOp(8'h01, 24'h000001, res);
    check("R5 R7 omega pass0 steer", 32'(res), 32'h10);

    // R6, R7: flip field 0 bit0 only.
    runOp(8'h01, 24'h001000, res);
    check("R6 R7 flip pass0 steer", 32'(res), 32'h02);

    // R11: result held over idle cycles.
    repeat (5) tick();
    check("R11 held result", 32'(dataOut), 32'h02);

    // R8: round trips with random masks.
    for (int n = 0; n < 8; n++) begin
      logic [W-1:0] d = W'($urandom);
      for (int k = 0; k < 3; k++) om[k] = 4'($urandom);
      runOp(d, {om[0], om[1], om[2], om[2], om[1], om[0]}, res);
      check("R8 round trip", 32'(res), 32'(d));
    end

    // R2: start in the done cycle is accepted at once.
    runOp(8'h3C, 24'h5A3C96, res);
    launch(8'hC3, 24'h0F1E2D);
    check("R2 restart from done", 32'(busy), 32'd1);
    repeat (6) tick();

    // R10: start while busy is ignored.
    launch(8'h96, 24'h123456);
    tick(); tick();
    start = 1'b1; dataIn = 8'hFF; maskIn = '1;
    tick();
    start = 1'b0;
    repeat (3) tick();
    check("R10 mid-run start ignored", 32'(done), 32'd1);
    tick();
    check("R10 engine idle after run", 32'(busy), 32'd0);

    // Random runs against the model.
    for (int n = 0; n < 6; n++) begin
      runOp(W'($urandom), MW'($urandom), res);
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule